// File: doc/BRIEF.md
# Mailbox Timer Command Processor

This block sits behind a host-to-service mailbox. When the mailbox raises a one-cycle trigger, the block reads four 64-bit command words and decodes word 0 into a command code, a sequence number and a set of control flags. If the host asked for an acknowledge, the block asks for the "message read" bit of the host doorbell to be set. This happens for every message, whatever the command.

Only one command has an effect: timer control. It can start, restart or stop a one-shot countdown measured in microseconds. A prescaler divides the system clock by a parameterised number of cycles per microsecond. When the countdown runs out, the block asks for the "timer expired" doorbell bit to be set. Both requests leave through a single registered set-mask, which the doorbell register ORs into its existing contents.

Top module: `mbox_cmd_proc`

## Requirements
- R1: After reset, `db_set_valid` is 0, `db_set_mask` is all zero, and no timer runs.
- R2: Word 0 is decoded as follows: command code in bits [15:0], sequence number in bits [31:16], flags in bits [47:32]. If flag bit 9 (value 0x0200) is set, then in the cycle after the trigger `db_set_valid` is 1 and `db_set_mask` bit 62 is set. Bit 62 is doorbell bit 1 counted from the MSB. This holds for any command code.
- R3: A message without the acknowledge flag and without a timer action produces no doorbell request. `db_set_valid` is high only in a cycle that follows a trigger or a timer expiry.
- R4: Command code 0xD401 with flag bit 0 (value 0x0001) loads the timer with D, the low CNT_W bits of word 1. Let E be the trigger edge. The expiry request, which is `db_set_mask` bit 49 (doorbell bit 14 counted from the MSB), appears in the cycle after edge E+(D+1)*CYC_PER_US.
- R5: A duration of 0 expires on the first microsecond tick, CYC_PER_US edges after the start.
- R6: Command 0xD401 with flag bit 1 (value 0x0002) stops a running timer, and no expiry follows.
- R7: Command 0xD401 with both start and stop flags applies the start first and then the stop, so the timer ends stopped and no expiry follows.
- R8: A start while the timer runs reloads the count and restarts the microsecond phase. Exactly one expiry follows, timed from the restart.
- R9: The timer is one-shot. Each start produces at most one expiry pulse.
- R10: Any command code other than 0xD401 (for example 0xD402 or 0xC401) has no timer effect, even with the start flag set.
- R11: If an acknowledge and an expiry fall on the same edge, a single output cycle carries both mask bits 62 and 49.
- R12: The sequence number and the response-requested flag (bit 8, value 0x0100) have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | One-cycle pulse: a message is waiting |
| msg_word0 | input | 64 | Command word: code, sequence number, flags |
| msg_word1 | input | 64 | Timer duration in microseconds |
| msg_word2 | input | 64 | Command word 2, unused by the supported command |
| msg_word3 | input | 64 | Command word 3, unused by the supported command |
| db_set_valid | output | 1 | One-cycle request to OR `db_set_mask` into the host doorbell |
| db_set_mask | output | 64 | Doorbell bits to set (bit 62 message read, bit 49 timer expired) |

## Verification
A fault in the acknowledge path shows up one cycle after the trigger, as a missing or extra bit 62. Faults in the countdown or the prescaler take longer to show. A wrong count or a bad reload only appears when the expiry pulse lands on the wrong edge, which can be up to (D+1)*CYC_PER_US cycles after the start. A timer that fails to stop, or that fires twice, shows as an extra bit-49 pulse long after the command. For this reason the bench compares both outputs with an edge-accurate model on every cycle, and it keeps idling after each expiry so that late or duplicate pulses are exposed.

// File: rtl/mbox_cmd_pkg.sv
package mbox_cmd_pkg;

    localparam int WORD_W = 64;

    // command code that drives the microsecond timer
    localparam logic [15:0] CMD_TIMER_CTRL = 16'hD401;
    localparam logic [7:0]  CLASS_LO       = 8'hD1;
    localparam logic [7:0]  CLASS_HI       = 8'hD7;

    // flag bit positions inside the 16-bit flag field
    localparam int FLG_START = 0;
    localparam int FLG_STOP  = 1;
    localparam int FLG_RESP  = 8;
    localparam int FLG_ACK   = 9;

    // doorbell bit positions (LSB-indexed); the doorbell counts from the MSB
    localparam int DB_MSG_READ_IDX = WORD_W - 1 - 1;
    localparam int DB_TMR_EXP_IDX  = WORD_W - 1 - 14;

    typedef struct packed {
        logic [15:0] code;
        logic [15:0] seq;
        logic [15:0] flags;
        logic        class_ok;
        logic        is_timer;
        logic        want_ack;
        logic        want_resp;
        logic        tmr_start;
        logic        tmr_stop;
    } msg_fields_t;

endpackage

// File: rtl/mbox_cmd_decode.sv
module mbox_cmd_decode
    import mbox_cmd_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    output msg_fields_t       fields
);

    always_comb begin
        fields           = '0;
        fields.code      = word0[15:0];
        fields.seq       = word0[31:16];
        fields.flags     = word0[47:32];
        fields.class_ok  = (word0[15:8] >= CLASS_LO) && (word0[15:8] <= CLASS_HI);
        fields.is_timer  = (word0[15:0] == CMD_TIMER_CTRL);
        fields.want_ack  = fields.flags[FLG_ACK];
        fields.want_resp = fields.flags[FLG_RESP];
        fields.tmr_start = fields.flags[FLG_START];
        fields.tmr_stop  = fields.flags[FLG_STOP];
    end

endmodule

// File: rtl/mbox_us_prescaler.sv
module mbox_us_prescaler #(
    parameter int CYC_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int PS_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PS_W-1:0] LAST = PS_W'(CYC_PER_US - 1);

    logic [PS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = cnt_q;
        if (restart || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    generate
        if (CYC_PER_US > 1) begin : g_wrap_chk
            // R4: one tick per microsecond, never two in a row
            assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

    // R8: a restart realigns the microsecond phase
    assert_restart_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/mbox_us_countdown.sv
module mbox_us_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] dur,
    input  logic             stop,
    output logic             expire,
    output logic             running
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] count;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load || stop) begin
            if (load) begin
                st_d.run   = 1'b1;
                st_d.count = dur;
            end
            if (stop) begin
                st_d.run = 1'b0;
            end
        end else if (st_q.run && tick) begin
            if (st_q.count == '0) begin
                expire   = 1'b1;
                st_d.run = 1'b0;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
    end

    assign running = st_q.run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a start loads the duration and arms the timer
    assert_load_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !stop) |=> (running && st_q.count == $past(dur)));

    // R6 / R7: a stop leaves the timer idle, even with a start on the same edge
    assert_stop_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !running);

    // R9: after an expiry the timer is idle
    assert_one_shot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !running);

    // R4: the count steps down once per tick
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !load && !stop && st_q.count != '0)
        |=> (running && st_q.count == $past(st_q.count) - 1'b1));

endmodule

// File: rtl/mbox_cmd_proc.sv
module mbox_cmd_proc
    import mbox_cmd_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [WORD_W-1:0] msg_word0,
    input  logic [WORD_W-1:0] msg_word1,
    input  logic [WORD_W-1:0] msg_word2,
    input  logic [WORD_W-1:0] msg_word3,
    output logic              db_set_valid,
    output logic [WORD_W-1:0] db_set_mask
);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] mask;
    } out_state_t;

    msg_fields_t fields;
    logic        tmr_load;
    logic        tmr_stop;
    logic        us_tick;
    logic        tmr_expire;
    logic        tmr_running;
    out_state_t  out_d, out_q;

    mbox_cmd_decode u_decode (
        .word0  (msg_word0),
        .fields (fields)
    );

    assign tmr_load = msg_valid && fields.is_timer && fields.tmr_start;
    assign tmr_stop = msg_valid && fields.is_timer && fields.tmr_stop;

    mbox_us_prescaler #(.CYC_PER_US(CYC_PER_US)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_load),
        .tick    (us_tick)
    );

    mbox_us_countdown #(.CNT_W(CNT_W)) u_countdown (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (us_tick),
        .load    (tmr_load),
        .dur     (msg_word1[CNT_W-1:0]),
        .stop    (tmr_stop),
        .expire  (tmr_expire),
        .running (tmr_running)
    );

    always_comb begin
        out_d      = '0;
        if (msg_valid && fields.want_ack) begin
            out_d.mask[DB_MSG_READ_IDX] = 1'b1;
        end
        if (tmr_expire) begin
            out_d.mask[DB_TMR_EXP_IDX] = 1'b1;
        end
        out_d.valid = |out_d.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign db_set_valid = out_q.valid;
    assign db_set_mask  = out_q.mask;

    logic unused_bits;
    assign unused_bits = ^{fields, tmr_running, msg_word0[63:48],
                           msg_word1[WORD_W-1:CNT_W], msg_word2, msg_word3};

    // R2: an acknowledge request sets the message-read bit one cycle later
    assert_ack_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_word0[32 + FLG_ACK]) |=> (db_set_valid && db_set_mask[DB_MSG_READ_IDX]));

    // R3: no request without a trigger or an expiry
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        db_set_valid |-> ($past(msg_valid) || $past(tmr_expire)));

    // R4: the expiry bit follows an expiry
    assert_expiry_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire |=> (db_set_valid && db_set_mask[DB_TMR_EXP_IDX]));

    // R10: only the timer command arms the countdown
    assert_timer_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_running && !(msg_valid && msg_word0[15:0] == CMD_TIMER_CTRL)) |=> !tmr_running);

endmodule

// File: tb/mbox_cmd_proc_bench.sv
module mbox_cmd_proc_bench;

    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [63:0] w0 = '0, w1 = '0, w2 = '0, w3 = '0;
    logic        db_set_valid;
    logic [63:0] db_set_mask;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    mbox_cmd_proc #(.CYC_PER_US(P), .CNT_W(32)) u_mbox_cmd_proc (
        .clk          (clk),
        .rst_n        (rst_n),
        .msg_valid    (msg_valid),
        .msg_word0    (w0),
        .msg_word1    (w1),
        .msg_word2    (w2),
        .msg_word3    (w3),
        .db_set_valid (db_set_valid),
        .db_set_mask  (db_set_mask)
    );

    // behavioural reference: deadlines counted in edges
    logic        m_valid = 1'b0;
    logic [63:0] m_mask = '0;
    longint      edge_n = 0;
    longint      deadline = -1;

    always @(posedge clk) begin
        logic [63:0] m;
        logic        fire;
        logic        is_tmr;
        if (!rst_n) begin
            m_valid  <= 1'b0;
            m_mask   <= '0;
            edge_n   = 0;
            deadline = -1;
        end else begin
            edge_n = edge_n + 1;
            fire   = (deadline == edge_n);
            is_tmr = msg_valid && (w0[15:0] == 16'hD401);
            if (is_tmr && (w0[32] || w0[33])) fire = 1'b0;
            if (fire) deadline = -1;
            if (is_tmr && w0[32]) deadline = edge_n + (longint'(w1[31:0]) + 1) * P;
            if (is_tmr && w0[33]) deadline = -1;
            m = '0;
            if (msg_valid && w0[41]) m[62] = 1'b1;
            if (fire) m[49] = 1'b1;
            m_valid <= |m;
            m_mask  <= m;
        end
    end

    int exp_pulses = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (db_set_valid !== m_valid || db_set_mask !== m_mask) begin
                failures++;
                $display("FAIL %s: valid=%0b mask=%h expected valid=%0b mask=%h",
                         cur_req, db_set_valid, db_set_mask, m_valid, m_mask);
            end
            if (db_set_valid && db_set_mask[49]) exp_pulses++;
        end
    end

    function automatic logic [63:0] mk_w0(input logic [15:0] code, input logic [15:0] seq,
                                          input logic [15:0] flags);
        return {16'h0000, flags, seq, code};
    endfunction

    // called at a negedge; the message is sampled on the next edge
    task automatic send(input logic [63:0] a, input logic [63:0] b);
        msg_valid = 1'b1;
        w0 = a;
        w1 = b;
        w2 = 64'hA5A5_0000_FFFF_1234;
        w3 = ~w2;
        @(negedge clk);
        msg_valid = 1'b0;
        w0 = '0;
        w1 = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic ok, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        cur_req = "R1";
        check("R1", db_set_valid === 1'b0 && db_set_mask === '0, db_set_mask, '0);
        rst_n = 1'b1;
        idle(2);
        check("R1", db_set_valid === 1'b0, {63'd0, db_set_valid}, '0);

        cur_req = "R2";
        send(mk_w0(16'hD702, 16'h1234, 16'h0200), 64'd0);
        check("R2", db_set_valid === 1'b1 && db_set_mask === 64'h4000_0000_0000_0000,
              db_set_mask, 64'h4000_0000_0000_0000);
        idle(3);

        cur_req = "R3";
        send(mk_w0(16'hD101, 16'h0007, 16'h0001), 64'd5);
        check("R3", db_set_valid === 1'b0, {63'd0, db_set_valid}, '0);
        idle(30);

        cur_req = "R4";
        exp_pulses = 0;
        send(mk_w0(16'hD401, 16'h0001, 16'h0201), 64'd3);
        idle(40);
        cur_req = "R9";
        check("R9", exp_pulses == 1, 64'(exp_pulses), 64'd1);

        cur_req = "R5";
        send(mk_w0(16'hD401, 16'h0002, 16'h0001), 64'd0);
        idle(P - 1);
        check("R5", db_set_valid === 1'b0, {63'd0, db_set_valid}, '0);
        idle(1);
        check("R5", db_set_valid === 1'b1 && db_set_mask === 64'h0002_0000_0000_0000,
              db_set_mask, 64'h0002_0000_0000_0000);
        idle(8);

        cur_req = "R6";
        exp_pulses = 0;
        send(mk_w0(16'hD401, 16'h0003, 16'h0001), 64'd5);
        idle(6);
        send(mk_w0(16'hD401, 16'h0004, 16'h0002), 64'd0);
        idle(40);
        check("R6", exp_pulses == 0, 64'(exp_pulses), 64'd0);

        cur_req = "R7";
        send(mk_w0(16'hD401, 16'h0005, 16'h0003), 64'd1);
        idle(20);
        check("R7", exp_pulses == 0, 64'(exp_pulses), 64'd0);

        cur_req = "R8";
        send(mk_w0(16'hD401, 16'h0006, 16'h0001), 64'd4);
        idle(10);
        send(mk_w0(16'hD401, 16'h0007, 16'h0001), 64'd2);
        idle(40);
        check("R8", exp_pulses == 1, 64'(exp_pulses), 64'd1);

        cur_req = "R10";
        exp_pulses = 0;
        send(mk_w0(16'hD402, 16'h0008, 16'h0001), 64'd0);
        send(mk_w0(16'hC401, 16'h0009, 16'h0001), 64'd0);
        idle(20);
        check("R10", exp_pulses == 0, 64'(exp_pulses), 64'd0);

        cur_req = "R11";
        send(mk_w0(16'hD401, 16'h000A, 16'h0001), 64'd0);
        idle(P - 1);
        send(mk_w0(16'hD705, 16'h000B, 16'h0200), 64'd0);
        check("R11", db_set_mask === 64'h4002_0000_0000_0000, db_set_mask,
              64'h4002_0000_0000_0000);
        idle(8);

        cur_req = "R12";
        send(mk_w0(16'hD702, 16'hFFFF, 16'h0100), 64'd0);
        check("R12", db_set_valid === 1'b0, {63'd0, db_set_valid}, '0);
        send(mk_w0(16'hD702, 16'hBEEF, 16'h0300), 64'd0);
        check("R12", db_set_mask === 64'h4000_0000_0000_0000, db_set_mask,
              64'h4000_0000_0000_0000);
        idle(10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule